// File: doc/BRIEF.md
# Audio Serial Interface Clock Master

This block is the clock master of a serial digital audio link. It divides a system clock by a programmable even ratio to make the bit clock, and counts bit-clock periods to make the frame clock. The frame clock takes one of two shapes. In the two-channel formats it is a half-frame channel select. In the DSP formats it is a sync pulse of programmable width. Both clocks can be inverted on their own.

For each bit slot the block gives the data shifters two single-cycle strobes in the system clock domain. One marks the instant when transmit data should change. The other marks the instant when receive data should be sampled. The block also gives a frame-start strobe and the index of the current slot. Divider ratio, slot count, sync width, format and inversions are taken in only at a frame boundary, or at any cycle while idle. A synchronous enable starts a frame at slot 0 on the next clock. Dropping the enable lets the current frame run to its end before the clocks go idle.

Format codes on `fmt_sel`: 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP-A, 4 = DSP-B. Other codes behave as 0.

Top module: `aud_clkgen`

## Requirements
- R1: After reset, `bclk`, `lrc`, `tx_stb`, `rx_stb`, `frame_start`, `busy` and `slot_idx` are all 0.
- R2: While running, one bit-clock period lasts `div_ratio` system clocks. Taking raw bclk as `bclk` XOR `bclk_inv`, raw bclk is low for the first `div_ratio/2` cycles of each period and high for the rest.
- R3: `tx_stb` is high for exactly the first cycle of each bit period, which is the first cycle after raw bclk falls. `rx_stb` is high for exactly the first cycle in which raw bclk is high. Setting `bclk_inv` complements `bclk` and does not move either strobe.
- R4: A frame holds `frame_bits` bit periods. `slot_idx` counts 0 to `frame_bits-1`, and `frame_start` is high together with `tx_stb` in slot 0.
- R5: In I2S (code 0), raw lrc (`lrc` XOR `lrc_inv`) is high in slots H-1 to 2H-2, where H = `frame_bits/2`, and low in every other slot. It therefore falls one slot before slot 0.
- R6: In left- and right-justified (codes 1, 2), raw lrc is high in slots 0 to H-1 and low in the rest.
- R7: In DSP-A (code 3), raw lrc is high in the last slot of the frame and in slots 0 to `sync_width-2`.
- R8: In DSP-B (code 4), raw lrc is high in slots 0 to `sync_width-1`.
- R9: Setting `lrc_inv` complements `lrc` in every format and while idle.
- R10: While running, `lrc` changes only in a cycle where `tx_stb` is high, which is a raw bclk falling edge.
- R11: A change of configuration inputs during a frame has no effect until the next frame begins.
- R12: When `en` goes high while idle, the next cycle is slot 0 with `busy` high. When `en` is low at the end of a frame, the frame completes and the next cycle is idle: `busy` is 0, raw bclk and raw lrc are 0, and there are no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request, sampled while idle and at frame end |
| fmt_sel | input | 3 | Frame format code |
| bclk_inv | input | 1 | Invert bit clock |
| lrc_inv | input | 1 | Invert frame clock |
| div_ratio | input | DIV_W | System clocks per bit period (even, at least 2) |
| frame_bits | input | FRM_W | Bit periods per frame (even, at least 4) |
| sync_width | input | FRM_W | DSP sync pulse width in bit periods (1 to frame_bits/2) |
| bclk | output | 1 | Bit clock |
| lrc | output | 1 | Frame clock |
| tx_stb | output | 1 | Transmit-change strobe |
| rx_stb | output | 1 | Receive-sample strobe |
| frame_start | output | 1 | Slot 0 strobe |
| slot_idx | output | FRM_W | Current slot index |
| busy | output | 1 | Generation running |

## Verification
The assertions assume legal settings. The divider ratio must be even and at least 2. The frame length must be even and at least 4. The sync width must lie between 1 and half the frame, and the format code must be 0 to 4. Under those conditions the two strobes can never fall in the same cycle, and every frame-clock edge lands on a transmit strobe. The directed stimulus writes only legal combinations. It changes settings in the middle of a frame on purpose, to show they wait for the boundary, and it drops the enable both early in a frame and just after a frame boundary.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
   typedef enum logic [2:0] {
      FMT_I2S  = 3'd0,
      FMT_LJ   = 3'd1,
      FMT_RJ   = 3'd2,
      FMT_DSPA = 3'd3,
      FMT_DSPB = 3'd4
   } fmt_e;
endpackage

// File: rtl/aud_clkgen_lrshape.sv
module aud_clkgen_lrshape
   import aud_clkgen_pkg::*;
#(
   parameter int FRM_W = 9
) (
   input  logic [2:0]       fmt,
   input  logic [FRM_W-1:0] slot,
   input  logic [FRM_W-1:0] len,
   input  logic [FRM_W-1:0] pw,
   output logic             level
);
   localparam int EW = FRM_W + 1;

   logic [FRM_W-1:0] half;
   logic [FRM_W-1:0] last;
   logic [EW-1:0]    slot_p1;

   always_comb begin
      half    = len >> 1;
      last    = len - FRM_W'(1);
      slot_p1 = {1'b0, slot} + EW'(1);
      case (fmt_e'(fmt))
         FMT_LJ, FMT_RJ: level = (slot < half);
         FMT_DSPA:       level = (slot == last) || (slot_p1 < {1'b0, pw});
         FMT_DSPB:       level = (slot < pw);
         default:        level = (slot >= half - FRM_W'(1)) && (slot != last);
      endcase
   end
endmodule

// File: rtl/aud_clkgen_seq.sv
module aud_clkgen_seq #(
   parameter int DIV_W = 8,
   parameter int FRM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_in,
   input  logic [FRM_W-1:0] len_in,
   input  logic [FRM_W-1:0] pw_in,
   input  logic [2:0]       fmt_in,
   input  logic             binv_in,
   input  logic             linv_in,
   output logic             running,
   output logic [DIV_W-1:0] pc,
   output logic [FRM_W-1:0] slot,
   output logic [DIV_W-1:0] div_q,
   output logic [FRM_W-1:0] len_q,
   output logic [FRM_W-1:0] pw_q,
   output logic [2:0]       fmt_q,
   output logic             binv_q,
   output logic             linv_q,
   output logic             run_n,
   output logic [DIV_W-1:0] pc_n,
   output logic [FRM_W-1:0] slot_n,
   output logic [DIV_W-1:0] div_n,
   output logic [FRM_W-1:0] len_n,
   output logic [FRM_W-1:0] pw_n,
   output logic [2:0]       fmt_n,
   output logic             binv_n,
   output logic             linv_n
);
   logic pc_wrap, eof, load;

   always_comb begin
      pc_wrap = (pc == div_q - DIV_W'(1));
      eof     = running && pc_wrap && (slot == len_q - FRM_W'(1));
      load    = !running || eof;
      div_n   = load ? div_in  : div_q;
      len_n   = load ? len_in  : len_q;
      pw_n    = load ? pw_in   : pw_q;
      fmt_n   = load ? fmt_in  : fmt_q;
      binv_n  = load ? binv_in : binv_q;
      linv_n  = load ? linv_in : linv_q;
      if (!running) begin
         run_n  = en;
         pc_n   = '0;
         slot_n = '0;
      end else if (pc_wrap) begin
         pc_n = '0;
         if (eof) begin
            slot_n = '0;
            run_n  = en;
         end else begin
            slot_n = slot + FRM_W'(1);
            run_n  = 1'b1;
         end
      end else begin
         pc_n   = pc + DIV_W'(1);
         slot_n = slot;
         run_n  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         pc      <= '0;
         slot    <= '0;
         div_q   <= DIV_W'(2);
         len_q   <= FRM_W'(4);
         pw_q    <= FRM_W'(1);
         fmt_q   <= '0;
         binv_q  <= 1'b0;
         linv_q  <= 1'b0;
      end else begin
         running <= run_n;
         pc      <= pc_n;
         slot    <= slot_n;
         div_q   <= div_n;
         len_q   <= len_n;
         pw_q    <= pw_n;
         fmt_q   <= fmt_n;
         binv_q  <= binv_n;
         linv_q  <= linv_n;
      end
   end

   // R2: the phase counter never leaves the bit period
   a_r2_pc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (pc < div_q));

   // R12: generation stops only right after the last cycle of a frame
   a_r12_stop_eof: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(running) |-> (($past(slot) == $past(len_q) - FRM_W'(1)) &&
                          ($past(pc) == $past(div_q) - DIV_W'(1))));

   // R11: settings held for the whole frame
   a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && $past(running) && !(pc == '0 && slot == '0))
      |-> ($stable(div_q) && $stable(len_q) && $stable(fmt_q)));
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
   parameter int DIV_W   = 8,
   parameter int FRM_W   = 9,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [2:0]       fmt_sel,
   input  logic             bclk_inv,
   input  logic             lrc_inv,
   input  logic [DIV_W-1:0] div_ratio,
   input  logic [FRM_W-1:0] frame_bits,
   input  logic [FRM_W-1:0] sync_width,
   output logic             bclk,
   output logic             lrc,
   output logic             tx_stb,
   output logic             rx_stb,
   output logic             frame_start,
   output logic [FRM_W-1:0] slot_idx,
   output logic             busy
);
   if (DIV_W < 2) begin : g_bad_div
      $error("aud_clkgen: DIV_W must be at least 2");
   end
   if (FRM_W < 3) begin : g_bad_frm
      $error("aud_clkgen: FRM_W must be at least 3");
   end

   logic             running, run_n;
   logic [DIV_W-1:0] pc, pc_n, div_q, div_n;
   logic [FRM_W-1:0] slot, slot_n, len_q, len_n, pw_q, pw_n;
   logic [2:0]       fmt_q, fmt_n;
   logic             binv_q, binv_n, linv_q, linv_n;

   aud_clkgen_seq #(.DIV_W(DIV_W), .FRM_W(FRM_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .div_in(div_ratio), .len_in(frame_bits), .pw_in(sync_width),
      .fmt_in(fmt_sel), .binv_in(bclk_inv), .linv_in(lrc_inv),
      .running(running), .pc(pc), .slot(slot),
      .div_q(div_q), .len_q(len_q), .pw_q(pw_q), .fmt_q(fmt_q),
      .binv_q(binv_q), .linv_q(linv_q),
      .run_n(run_n), .pc_n(pc_n), .slot_n(slot_n),
      .div_n(div_n), .len_n(len_n), .pw_n(pw_n), .fmt_n(fmt_n),
      .binv_n(binv_n), .linv_n(linv_n)
   );

   if (REG_OUT) begin : g_reg_out
      logic lv_n, bclk_q, lrc_q;
      aud_clkgen_lrshape #(.FRM_W(FRM_W)) shape_i (
         .fmt(fmt_n), .slot(slot_n), .len(len_n), .pw(pw_n), .level(lv_n));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bclk_q <= 1'b0;
            lrc_q  <= 1'b0;
         end else begin
            bclk_q <= (run_n && (pc_n >= (div_n >> 1))) ^ binv_n;
            lrc_q  <= (run_n && lv_n) ^ linv_n;
         end
      end
      assign bclk = bclk_q;
      assign lrc  = lrc_q;
   end else begin : g_dec_out
      logic lv;
      aud_clkgen_lrshape #(.FRM_W(FRM_W)) shape_i (
         .fmt(fmt_q), .slot(slot), .len(len_q), .pw(pw_q), .level(lv));
      assign bclk = (running && (pc >= (div_q >> 1))) ^ binv_q;
      assign lrc  = (running && lv) ^ linv_q;
   end

   assign tx_stb      = running && (pc == '0);
   assign rx_stb      = running && (pc == (div_q >> 1));
   assign frame_start = tx_stb && (slot == '0);
   assign slot_idx    = slot;
   assign busy        = running;

   // R3: the two strobes never share a cycle
   a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_stb, rx_stb}));

   // R3: transmit strobe sits in the raw-low half, receive strobe in the raw-high half
   a_r3_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb |-> ((bclk ^ binv_q) == 1'b0));
   a_r3_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb |-> ((bclk ^ binv_q) == 1'b1));

   // R10: frame clock edges coincide with a transmit strobe
   a_r10_lrc_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (lrc != $past(lrc))) |-> tx_stb);
endmodule

// File: tb/aud_clkgen_tb_top.sv
`timescale 1ns/1ps
module aud_clkgen_tb_top;
   localparam int DIV_W = 8;
   localparam int FRM_W = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [2:0]       fmt_sel = '0;
   logic             bclk_inv = 1'b0;
   logic             lrc_inv = 1'b0;
   logic [DIV_W-1:0] div_ratio = DIV_W'(4);
   logic [FRM_W-1:0] frame_bits = FRM_W'(8);
   logic [FRM_W-1:0] sync_width = FRM_W'(1);
   logic             bclk, lrc, tx_stb, rx_stb, frame_start, busy;
   logic [FRM_W-1:0] slot_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   aud_clkgen #(.DIV_W(DIV_W), .FRM_W(FRM_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .fmt_sel(fmt_sel),
      .bclk_inv(bclk_inv), .lrc_inv(lrc_inv), .div_ratio(div_ratio),
      .frame_bits(frame_bits), .sync_width(sync_width),
      .bclk(bclk), .lrc(lrc), .tx_stb(tx_stb), .rx_stb(rx_stb),
      .frame_start(frame_start), .slot_idx(slot_idx), .busy(busy));

   function automatic bit raw_lrc(int f, int s, int l, int p);
      int h = l / 2;
      case (f)
         1, 2:    return s < h;
         3:       return (s == l - 1) || (s < p - 1);
         4:       return s < p;
         default: return (s >= h - 1) && (s <= l - 2);
      endcase
   endfunction

   // expected {busy,bclk,lrc,tx,rx,fs,slot} at cycle k of a running frame sequence
   function automatic logic [FRM_W+5:0] model(int f, int bi, int li, int d,
                                             int l, int p, int k);
      int pc = k % d;
      int s  = (k / d) % l;
      logic b  = ((pc >= d / 2) ? 1'b1 : 1'b0) ^ bi[0];
      logic r  = raw_lrc(f, s, l, p) ^ li[0];
      logic t  = (pc == 0);
      logic x  = (pc == d / 2);
      logic fs = t && (s == 0);
      return {1'b1, b, r, t, x, fs, FRM_W'(s)};
   endfunction

   function automatic logic [FRM_W+5:0] actual();
      return {busy, bclk, lrc, tx_stb, rx_stb, frame_start, slot_idx};
   endfunction

   task automatic check(string req, logic [FRM_W+5:0] act, logic [FRM_W+5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         if (errors <= 20)
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive_cfg(int f, int bi, int li, int d, int l, int p);
      fmt_sel    = 3'(f);
      bclk_inv   = bi[0];
      lrc_inv    = li[0];
      div_ratio  = DIV_W'(d);
      frame_bits = FRM_W'(l);
      sync_width = FRM_W'(p);
   endtask

   // R12 idle state after stop: busy 0, raw clocks 0, no strobes
   task automatic check_idle(string req, int bi, int li);
      @(negedge clk);
      check(req, actual(), {1'b0, bi[0], li[0], 1'b0, 1'b0, 1'b0, FRM_W'(0)});
   endtask

   // run nfr frames; en drops just after the last frame begins
   task automatic run_frames(string req, int f, int bi, int li, int d,
                             int l, int p, int nfr);
      @(negedge clk);
      drive_cfg(f, bi, li, d, l, p);
      en = 1'b1;
      for (int k = 0; k < nfr * l * d; k++) begin
         @(negedge clk);
         check(req, actual(), model(f, bi, li, d, l, p, k));
         if (k == (nfr - 1) * l * d) en = 1'b0;
      end
      check_idle({req, " R12 idle"}, bi, li);
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset", actual(), '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", actual(), '0);
   endtask

   // R11: settings changed mid-frame take effect only at the next frame
   task automatic test_cfg_hold();
      @(negedge clk);
      drive_cfg(1, 0, 0, 4, 8, 1);
      en = 1'b1;
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         check("R11 old frame", actual(), model(1, 0, 0, 4, 8, 1, k));
         if (k == 3) drive_cfg(4, 1, 1, 2, 12, 3);
      end
      for (int k = 0; k < 24; k++) begin
         @(negedge clk);
         check("R11 new frame", actual(), model(4, 1, 1, 2, 12, 3, k));
         if (k == 0) en = 1'b0;
      end
      check_idle("R11 R12 idle", 1, 1);
   endtask

   // R12: en high for one cycle while idle still yields one whole frame
   task automatic test_en_pulse();
      @(negedge clk);
      drive_cfg(0, 0, 0, 2, 4, 1);
      en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check("R12 start slot0", actual(), model(0, 0, 0, 2, 4, 1, 0));
      for (int k = 1; k < 8; k++) begin
         @(negedge clk);
         check("R12 frame completes", actual(), model(0, 0, 0, 2, 4, 1, k));
      end
      check_idle("R12 stop", 0, 0);
   endtask

   initial begin
      #(4ns * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      test_reset();
      run_frames("R2 R3 R4 R5 i2s", 0, 0, 0, 4, 16, 1, 2);
      run_frames("R3 R6 lj bclk_inv", 1, 1, 0, 2, 8, 1, 2);
      run_frames("R6 R9 rj lrc_inv", 2, 0, 1, 6, 8, 1, 1);
      run_frames("R7 dspa width1", 3, 0, 0, 4, 8, 1, 2);
      run_frames("R7 dspa width3", 3, 0, 0, 2, 10, 3, 2);
      run_frames("R8 R9 dspb half-frame inv", 4, 0, 1, 4, 8, 4, 2);
      run_frames("R5 R9 i2s both inv", 0, 1, 1, 8, 6, 1, 1);
      test_cfg_hold();
      test_en_pulse();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule